// File: doc/BRIEF.md
# GPIO Expander Register Core

This block is a byte-wide register map that drives and samples 24 pins of an I/O expander. A host reaches it through a plain synchronous bus with an address, write data, a write strobe, a read strobe and read data. Read data appears one cycle after the read strobe. The pins come in three classes:

- Eight general-purpose pins, each with its own control byte. They can be driven or used as inputs, and they can raise interrupts on rising or falling edges.
- A bank of switched outputs. Six of its eight slots have a control byte; the other two slots are never driven.
- Eight plain outputs packed into one byte.

General-purpose inputs pass through a two-flop synchronizer. An edge is found by comparing the synchronized level with its value one clock earlier. An edge that is enabled latches a bit in a shared status byte. The single interrupt line is the OR of that byte. Reading the status byte returns it and clears it, so no mask register is needed. If an edge lands in the same cycle as the clearing read, its bit stays set.

Top module: `gpx_core`

## Requirements
- R1: After reset every control byte reads 0x00 and the status byte reads 0x00. `irq` is low. `pin_oe[15:0]` and `pin_out` are all zero. `pin_oe[23:16]` is all ones.
- R2: General-purpose control bytes live at 0xE0+n for pin n (n = 0..7). Bits 0 (drive), 1 (direction, 1 = input), 3 (value), 4 (fall enable), 5 (rise enable) and 7:6 (filter setting, stored only) read back as written.
- R3: For pin n in 0..7, `pin_oe[n]` = bit 0 AND NOT bit 1 of its control byte, and `pin_out[n]` = bit 3.
- R4: Bit 2 of control byte n reads the level of `gpio_in[n]` after the two-flop synchronizer. Values written to bit 2 are ignored.
- R5: A synchronized rising edge on pin n with bit 5 set sets status bit n. It is visible at `irq` on the third clock edge after the input changes.
- R6: A falling edge with bit 4 set also sets status bit n. With both bits set either edge sets it. With neither set, no edge sets it.
- R7: The status byte lives at 0xE8 and writes to it are ignored. A read returns its value and clears it. `irq` is the OR of its bits and falls only after such a read.
- R8: An enabled edge detected in the same cycle as a clearing read leaves its status bit set. The read returns the earlier value.
- R9: Switched-output control bytes live at 0xEC+k for channel k (k = 0..5), driving pin 8+k. Bits 0, 3 and 5:4 are stored; the other bits read 0. `pin_oe[8+k]` = bit 0 and `pin_out[8+k]` = bit 3.
- R10: Pins 14 and 15 are never driven, and their output value is always 0.
- R11: The byte at 0xF4 drives `pin_out[16+n]` from bit n. Pins 16..23 are always output-enabled.
- R12: Reads of any other address return 0x00 and writes to them change nothing. `bus_rdata` is 0x00 in any cycle not following a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, one cycle after `bus_rd` |
| gpio_in | input | 8 | Asynchronous levels of general-purpose pins 0..7 |
| pin_oe | output | 24 | Output enable per pin |
| pin_out | output | 24 | Output value per pin |
| irq | output | 1 | Combined interrupt, OR of status bits |

## Verification
The hardest case to reach is a clearing status read that meets a fresh edge in the same cycle. The bench first latches one pin's status bit. It then changes a second input at a falling clock edge and waits exactly two cycles before raising the read strobe, so the read is sampled on the clock edge where the second pin's edge is detected. It then checks that the read returns only the first bit and that a second read returns the second. A random loop mixes writes with random enables and single-pin toggles, and compares the status byte against a model built from the enable bits and the toggle direction.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 8;
  localparam int unsigned GPIO_N = 8;
  localparam int unsigned SW_SLOTS = 8;
  localparam int unsigned SW_N = 6;
  localparam int unsigned PO_N = 8;
  localparam int unsigned PIN_N = GPIO_N + SW_SLOTS + PO_N;

  localparam logic [AW-1:0] GPIO_BASE = 8'hE0;
  localparam logic [AW-1:0] STAT_ADDR = 8'hE8;
  localparam logic [AW-1:0] SW_BASE   = 8'hEC;
  localparam logic [AW-1:0] PO_ADDR   = 8'hF4;

  localparam int unsigned B_DRV  = 0;
  localparam int unsigned B_DIR  = 1;
  localparam int unsigned B_IN   = 2;
  localparam int unsigned B_VAL  = 3;
  localparam int unsigned B_FALL = 4;
  localparam int unsigned B_RISE = 5;

  localparam logic [DW-1:0] GPIO_WMASK = 8'hFB;
  localparam logic [DW-1:0] SW_WMASK   = 8'h39;
endpackage

// File: rtl/gpx_edge_sync.sv
module gpx_edge_sync #(
  parameter int unsigned N = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [STAGES-1:0][N-1:0] sh_q, sh_d;
  logic [N-1:0] prev_q;

  always_comb begin
    sh_d[0] = din;
    for (int i = 1; i < STAGES; i++) sh_d[i] = sh_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= '0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level = sh_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/gpx_irq_stat.sv
module gpx_irq_stat #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr,
  output logic [N-1:0] stat
);
  logic [N-1:0] stat_q, stat_d;
  logic         stat_en;

  always_comb begin
    stat_en = clr | (|set_vec);
    stat_d  = (stat_q & ~{N{clr}}) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat = stat_q;
endmodule

// File: rtl/gpx_regbank.sv
module gpx_regbank
  import gpx_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  output logic [GPIO_N-1:0][DW-1:0]  gpio_ctl,
  output logic [SW_N-1:0][DW-1:0]    sw_ctl,
  output logic [DW-1:0]              po_reg
);
  logic [GPIO_N-1:0] gpio_we;
  logic [SW_N-1:0]   sw_we;
  logic              po_we;

  for (genvar g = 0; g < GPIO_N; g++) begin : g_gpio
    logic [DW-1:0] ctl_q, ctl_d;
    assign gpio_we[g] = wr_en && (addr == GPIO_BASE + AW'(g));
    assign ctl_d = wdata & GPIO_WMASK;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= '0;
      else if (gpio_we[g]) ctl_q <= ctl_d;
    end
    assign gpio_ctl[g] = ctl_q;
  end

  for (genvar k = 0; k < SW_N; k++) begin : g_sw
    logic [DW-1:0] ctl_q, ctl_d;
    assign sw_we[k] = wr_en && (addr == SW_BASE + AW'(k));
    assign ctl_d = wdata & SW_WMASK;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= '0;
      else if (sw_we[k]) ctl_q <= ctl_d;
    end
    assign sw_ctl[k] = ctl_q;
  end

  logic [DW-1:0] po_q;
  assign po_we = wr_en && (addr == PO_ADDR);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) po_q <= '0;
    else if (po_we) po_q <= wdata;
  end
  assign po_reg = po_q;
endmodule

// File: rtl/gpx_core.sv
module gpx_core
  import gpx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [7:0]       bus_rdata,
  input  logic [7:0]       gpio_in,
  output logic [23:0]      pin_oe,
  output logic [23:0]      pin_out,
  output logic             irq
);
  localparam int unsigned SW_LO = GPIO_N;
  localparam int unsigned PO_LO = GPIO_N + SW_SLOTS;

  logic [GPIO_N-1:0][DW-1:0] gpio_ctl;
  logic [SW_N-1:0][DW-1:0]   sw_ctl;
  logic [DW-1:0]             po_reg;
  logic [GPIO_N-1:0]         in_lvl, in_rise, in_fall;
  logic [GPIO_N-1:0]         en_rise, en_fall, stat_set, stat;
  logic                      stat_clr;
  logic [DW-1:0]             rd_val, rdata_d, rdata_q;

  gpx_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .gpio_ctl(gpio_ctl), .sw_ctl(sw_ctl), .po_reg(po_reg)
  );

  gpx_edge_sync #(.N(GPIO_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(gpio_in),
    .level(in_lvl), .rise(in_rise), .fall(in_fall)
  );

  for (genvar g = 0; g < GPIO_N; g++) begin : g_pin_gp
    assign en_rise[g]  = gpio_ctl[g][B_RISE];
    assign en_fall[g]  = gpio_ctl[g][B_FALL];
    assign pin_oe[g]   = gpio_ctl[g][B_DRV] & ~gpio_ctl[g][B_DIR];
    assign pin_out[g]  = gpio_ctl[g][B_VAL];
  end

  for (genvar s = 0; s < SW_SLOTS; s++) begin : g_pin_sw
    if (s < SW_N) begin : g_live
      assign pin_oe[SW_LO+s]  = sw_ctl[s][B_DRV];
      assign pin_out[SW_LO+s] = sw_ctl[s][B_VAL];
    end else begin : g_dead
      assign pin_oe[SW_LO+s]  = 1'b0;
      assign pin_out[SW_LO+s] = 1'b0;
    end
  end

  assign pin_oe[PO_LO +: PO_N]  = '1;
  assign pin_out[PO_LO +: PO_N] = po_reg;

  assign stat_set = (in_rise & en_rise) | (in_fall & en_fall);
  assign stat_clr = bus_rd && (bus_addr == STAT_ADDR);

  gpx_irq_stat #(.N(GPIO_N)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(stat_set), .clr(stat_clr), .stat(stat)
  );

  assign irq = |stat;

  always_comb begin
    rd_val = '0;
    for (int g = 0; g < GPIO_N; g++) begin
      if (bus_addr == GPIO_BASE + AW'(g)) begin
        rd_val = gpio_ctl[g];
        rd_val[B_IN] = in_lvl[g];
      end
    end
    for (int k = 0; k < SW_N; k++) begin
      if (bus_addr == SW_BASE + AW'(k)) rd_val = sw_ctl[k];
    end
    if (bus_addr == STAT_ADDR) rd_val = stat;
    if (bus_addr == PO_ADDR)   rd_val = po_reg;
    rdata_d = bus_rd ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpx_core_chk.sv
module gpx_core_chk
  import gpx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic [7:0] gp_oe,
  input logic [7:0] gp_out,
  input logic [5:0] sw_oe,
  input logic [5:0] sw_out,
  input logic [7:0] po_out,
  input logic       irq
);
  logic       gp_hit, sw_hit, st_rd;
  logic [2:0] sw_idx;

  assign gp_hit = bus_addr[7:3] == GPIO_BASE[7:3];
  assign sw_hit = (bus_addr >= SW_BASE) && (bus_addr < SW_BASE + 8'(SW_N));
  assign sw_idx = 3'(bus_addr - SW_BASE);
  assign st_rd  = bus_rd && (bus_addr == STAT_ADDR);

  assert_gp_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && gp_hit) |=>
      (gp_oe[$past(bus_addr[2:0])] == ($past(bus_wdata[0]) && !$past(bus_wdata[1])))
      && (gp_out[$past(bus_addr[2:0])] == $past(bus_wdata[3])));

  assert_sw_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sw_hit) |=>
      (sw_oe[$past(sw_idx)] == $past(bus_wdata[0]))
      && (sw_out[$past(sw_idx)] == $past(bus_wdata[3])));

  assert_po_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PO_ADDR) |=> po_out == $past(bus_wdata));

  assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(st_rd));

  assert_stat_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !irq) |=> bus_rdata == 8'h00);

  assert_stat_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && irq) |=> bus_rdata != 8'h00);

  assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 8'h00);
endmodule

bind gpx_core gpx_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .gp_oe(pin_oe[7:0]), .gp_out(pin_out[7:0]),
  .sw_oe(pin_oe[13:8]), .sw_out(pin_out[13:8]),
  .po_out(pin_out[23:16]), .irq(irq)
);

// File: tb/gpx_core_tb.sv
`timescale 1ns/1ps
module gpx_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr, bus_wdata, bus_rdata;
  logic        bus_wr, bus_rd;
  logic [7:0]  gpio_in;
  logic [23:0] pin_oe, pin_out;
  logic        irq;

  int total = 0;
  int bad = 0;

  logic [7:0] m_gp [8];
  logic [7:0] m_sw [6];
  logic [7:0] m_po;

  always #2.5 clk = ~clk;

  gpx_core dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .gpio_in(gpio_in), .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_oe();
    logic [23:0] v = 24'hFF0000;
    for (int n = 0; n < 8; n++) v[n] = m_gp[n][0] & ~m_gp[n][1];
    for (int k = 0; k < 6; k++) v[8+k] = m_sw[k][0];
    return v;
  endfunction

  function automatic logic [23:0] exp_out();
    logic [23:0] v = '0;
    for (int n = 0; n < 8; n++) v[n] = m_gp[n][3];
    for (int k = 0; k < 6; k++) v[8+k] = m_sw[k][3];
    v[23:16] = m_po;
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a >= 8'hE0 && a <= 8'hE7) return (m_gp[a[2:0]] & 8'hFB) | {5'd0, gpio_in[a[2:0]], 2'd0};
    if (a >= 8'hEC && a <= 8'hF1) return m_sw[a - 8'hEC];
    if (a == 8'hF4) return m_po;
    return 8'h00;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a >= 8'hE0 && a <= 8'hE7) m_gp[a[2:0]] = d & 8'hFB;
    else if (a >= 8'hEC && a <= 8'hF1) m_sw[a - 8'hEC] = d & 8'h39;
    else if (a == 8'hF4) m_po = d;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic check_pins(input string req);
    check({req, " oe"}, 32'(pin_oe), 32'(exp_oe()));
    check({req, " out"}, 32'(pin_out), 32'(exp_out()));
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    gpio_in = '0;
    for (int n = 0; n < 8; n++) m_gp[n] = '0;
    for (int k = 0; k < 6; k++) m_sw[k] = '0;
    m_po = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    check("R1 oe", 32'(pin_oe), 32'h00FF0000);
    check("R1 out", 32'(pin_out), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    do_rd(8'hE0, d); check("R1 E0", 32'(d), 32'h0);
    do_rd(8'hE8, d); check("R1 stat", 32'(d), 32'h0);
    do_rd(8'hEC, d); check("R1 EC", 32'(d), 32'h0);

    // R3 drive control
    do_wr(8'hE3, 8'h09); check_pins("R3 drive");
    do_wr(8'hE3, 8'h0B); check_pins("R3 input dir");
    check("R3 oe3 off", 32'(pin_oe[3]), 32'h0);
    // R2 readback
    do_wr(8'hE6, 8'hCB); do_rd(8'hE6, d); check("R2 readback", 32'(d), 32'hCB);

    // R4 input bit, write ignored
    gpio_in[5] = 1'b1; idle(3);
    do_wr(8'hE5, 8'h00); do_rd(8'hE5, d); check("R4 in high", 32'(d), 32'h04);
    gpio_in[5] = 1'b0; idle(3);
    do_wr(8'hE5, 8'h04); do_rd(8'hE5, d); check("R4 bit2 ignored", 32'(d), 32'h00);
    // R6 disabled edges set nothing
    check("R6 no enable irq", 32'(irq), 32'h0);

    // R5 rising edge, timing
    do_wr(8'hE0, 8'h20);
    gpio_in[0] = 1'b1;
    idle(2); check("R5 not yet", 32'(irq), 32'h0);
    idle(1); check("R5 irq rise", 32'(irq), 32'h1);
    do_rd(8'hE8, d); check("R5 stat", 32'(d), 32'h01);
    check("R7 irq cleared", 32'(irq), 32'h0);
    do_rd(8'hE8, d); check("R7 cleared", 32'(d), 32'h00);
    gpio_in[0] = 1'b0; idle(4);
    check("R5 fall ignored", 32'(irq), 32'h0);

    // R6 falling and both
    do_wr(8'hE1, 8'h10);
    gpio_in[1] = 1'b1; idle(4); check("R6 rise off", 32'(irq), 32'h0);
    gpio_in[1] = 1'b0; idle(4);
    do_rd(8'hE8, d); check("R6 fall", 32'(d), 32'h02);
    do_wr(8'hE2, 8'h30);
    gpio_in[2] = 1'b1; idle(4); do_rd(8'hE8, d); check("R6 both rise", 32'(d), 32'h04);
    gpio_in[2] = 1'b0; idle(4); do_rd(8'hE8, d); check("R6 both fall", 32'(d), 32'h04);

    // R7 write to status ignored
    do_wr(8'hE8, 8'hFF); check("R7 write ignored", 32'(irq), 32'h0);

    // R8 edge meets clearing read
    do_wr(8'hE0, 8'h20); do_wr(8'hE1, 8'h20);
    gpio_in[0] = 1'b1; idle(4);
    gpio_in[1] = 1'b1; idle(2);
    do_rd(8'hE8, d); check("R8 old value", 32'(d), 32'h01);
    check("R8 irq kept", 32'(irq), 32'h1);
    do_rd(8'hE8, d); check("R8 kept bit", 32'(d), 32'h02);

    // R9 / R10 switched outputs
    for (int k = 0; k < 6; k++) begin
      do_wr(8'hEC + 8'(k), 8'hFF);
      do_rd(8'hEC + 8'(k), d); check("R9 mask", 32'(d), 32'h39);
    end
    check_pins("R9 pins");
    check("R10 pins 14-15", 32'({pin_oe[15:14], pin_out[15:14]}), 32'h0);
    do_wr(8'hEE, 8'h08); check_pins("R9 off");

    // R11 plain outputs
    do_wr(8'hF4, 8'hA5); check("R11 out", 32'(pin_out[23:16]), 32'hA5);
    check("R11 oe", 32'(pin_oe[23:16]), 32'hFF);

    // R12 unmapped
    do_wr(8'hF2, 8'hFF); do_wr(8'hEA, 8'hFF); do_wr(8'h10, 8'hFF);
    check_pins("R12 write ignored");
    do_rd(8'hF2, d); check("R12 read F2", 32'(d), 32'h0);
    do_rd(8'hEB, d); check("R12 read EB", 32'(d), 32'h0);
    check("R12 idle rdata", 32'(bus_rdata), 32'h0);

    // Random register traffic, inputs held steady
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [7:0] v;
      a = (($urandom % 4) == 0) ? 8'($urandom) : 8'hE0 + 8'($urandom % 24);
      if (a == 8'hE8) a = 8'hE9;
      if ($urandom % 2) begin
        do_wr(a, 8'($urandom)); check_pins("R3 R9 R11 random");
      end else begin
        v = exp_rd(a); do_rd(a, d); check("R2 R12 random read", 32'(d), 32'(v));
      end
    end

    // Random edge trials against a status model
    do_rd(8'hE8, d);
    for (int i = 0; i < 60; i++) begin
      int p;
      logic [7:0] cfg;
      logic hit;
      p = int'($urandom % 8);
      cfg = 8'($urandom);
      do_wr(8'hE0 + 8'(p), cfg);
      gpio_in[p] = ~gpio_in[p];
      hit = gpio_in[p] ? cfg[5] : cfg[4];
      idle(4);
      check("R5 R6 random irq", 32'(irq), 32'(hit));
      do_rd(8'hE8, d);
      check("R5 R6 random stat", 32'(d), 32'(hit ? (8'h01 << p) : 8'h00));
      check_pins("R3 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule